// File: doc/BRIEF.md
# Result Broadcast Bus Arbiter

This block decides which finished operation may drive the single shared result bus of an out-of-order core in a given cycle. Three groups of producers can ask for the bus: the add/subtract reservation slots, the multiply/divide reservation slots and the load/store buffer entries. Each producer raises one request bit and presents its result value. The arbiter picks at most one winner using a fixed priority ordered by group, then by slot position. It hands the one-hot grant back in the same cycle so that the winning slot can release itself.

The broadcast itself is registered. On the clock edge after the grant, the bus shows a valid flag, a tag that names the producing group and slot, and the winner's value. In the same cycle as the grant, a write-back-active output tells the issue stage that the bus is taken, so it can hold the next instruction. Buffer entries that hold stores never compete for the bus, even if their request bit is set.

Top module: `cdb_arbiter`

## Requirements
- R1: At most one grant bit is set across the add/sub, mul/div and load grant vectors in any cycle. Exactly one is set whenever at least one eligible request is present.
- R2: The grant is combinational. It appears in the same cycle as the request that earns it.
- R3: If any add/sub slot requests, the add/sub slot with the lowest index is granted. A slot's index is its bit position in the request vector.
- R4: A mul/div slot is granted only when no add/sub slot requests. The lowest requesting mul/div index wins.
- R5: A load buffer entry is granted only when no add/sub and no mul/div slot requests. The lowest eligible load index wins.
- R6: A buffer entry whose store flag is 1 is never granted. If only store entries request, no grant is issued, write-back-active stays 0 and the bus is idle on the next edge.
- R7: On the clock edge after a grant, the bus shows valid=1, the winner's value, and the tag {class, index}. The class occupies the top two tag bits: add/sub=01, mul/div=10, load=11. The index occupies the low IDXW bits, and IDXW is 2 with the default sizes.
- R8: On the clock edge after a cycle with no grant, the bus shows valid=0, tag=0 and value=0.
- R9: write-back-active is 1 exactly in the cycles where a grant is issued.
- R10: A synchronous active-low reset clears the bus valid flag, tag and value, even while requests are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| add_req | input | N_ADD | Add/sub slot write-back requests |
| add_val | input | N_ADD*DW | Add/sub slot results, one DW word per slot |
| mul_req | input | N_MUL | Mul/div slot write-back requests |
| mul_val | input | N_MUL*DW | Mul/div slot results |
| ld_req | input | N_LD | Buffer entry write-back requests |
| ld_is_store | input | N_LD | 1 marks a buffer entry as a store |
| ld_val | input | N_LD*DW | Buffer entry load data |
| add_gnt | output | N_ADD | One-hot grant to add/sub slots |
| mul_gnt | output | N_MUL | One-hot grant to mul/div slots |
| ld_gnt | output | N_LD | One-hot grant to buffer entries |
| wb_active | output | 1 | Bus taken this cycle (issue stall) |
| cdb_valid | output | 1 | Registered bus valid / busy flag |
| cdb_tag | output | 2+IDXW | Registered producer tag {class, index} |
| cdb_value | output | DW | Registered result value |

## Verification
The bench targets the group boundaries: cases where every group requests at once, and cases where a lower group has a low-index request while a higher group asks only from a high index. A design that scans groups in the wrong order, or that prefers the highest index, grants the wrong slot and shows a mismatched tag. Store-flagged entries are mixed with real loads, and in one case only stores request. A design that lets stores through grants them, or raises write-back-active when nothing should broadcast. The bus is checked one edge after each grant, after idle cycles and under reset with requests held. This catches value mux mistakes, a stale tag left over from an idle cycle, and a reset that fails to win over incoming requests.

// File: rtl/cdb_pkg.sv
// Shared definitions for the result broadcast bus arbiter.
// Assumes the producer class code sits in the two top bits of the tag.
package cdb_pkg;
    typedef enum logic [1:0] {
        CLS_NONE   = 2'b00,
        CLS_ADDSUB = 2'b01,
        CLS_MULDIV = 2'b10,
        CLS_LOAD   = 2'b11
    } cdb_cls_e;
endpackage

// File: rtl/cdb_prio_pick.sv
// Lowest-index-first picker for one producer group.
// Returns a one-hot grant, a found flag, the binary index and the
// selected value. Assumes IW is wide enough to hold N-1.
module cdb_prio_pick #(
    parameter int N  = 3,
    parameter int IW = 2,
    parameter int DW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          req,
    input  logic [N-1:0][DW-1:0]  vals,
    output logic [N-1:0]          gnt,
    output logic                  any,
    output logic [IW-1:0]         idx,
    output logic [DW-1:0]         val
);
    // Scan upward and keep the first requester found.
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        val = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = IW'(i);
                val    = vals[i];
            end
        end
    end

    // R1
    pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((req != '0) == (gnt != '0)));

    // R3
    pick_granted_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/cdb_bus_reg.sv
// Registered broadcast stage of the result bus.
// Captures the arbiter's next valid/tag/value on every edge; the
// synchronous active-low reset returns the bus to idle.
module cdb_bus_reg #(
    parameter int TW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nxt_valid,
    input  logic [TW-1:0] nxt_tag,
    input  logic [DW-1:0] nxt_value,
    output logic          bus_valid,
    output logic [TW-1:0] bus_tag,
    output logic [DW-1:0] bus_value
);
    // Load the next broadcast, or clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_valid <= 1'b0;
            bus_tag   <= '0;
            bus_value <= '0;
        end else begin
            bus_valid <= nxt_valid;
            bus_tag   <= nxt_tag;
            bus_value <= nxt_value;
        end
    end

    // R8
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (bus_tag == '0 && bus_value == '0));

    // R7
    valid_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tag[TW-1 -: 2] != 2'b00));
endmodule

// File: rtl/cdb_arbiter.sv
// Result broadcast bus arbiter.
// Priority: add/sub slots, then mul/div slots, then non-store buffer
// entries, each group lowest index first. The grant is combinational;
// the broadcast is registered one edge later.
module cdb_arbiter
    import cdb_pkg::*;
#(
    parameter int N_ADD = 3,
    parameter int N_MUL = 2,
    parameter int N_LD  = 3,
    parameter int DW    = 32,
    localparam int NMAX = (N_ADD > N_MUL) ? ((N_ADD > N_LD) ? N_ADD : N_LD)
                                          : ((N_MUL > N_LD) ? N_MUL : N_LD),
    localparam int IDXW = (NMAX > 1) ? $clog2(NMAX) : 1,
    localparam int TW   = 2 + IDXW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_ADD-1:0]          add_req,
    input  logic [N_ADD-1:0][DW-1:0]  add_val,
    input  logic [N_MUL-1:0]          mul_req,
    input  logic [N_MUL-1:0][DW-1:0]  mul_val,
    input  logic [N_LD-1:0]           ld_req,
    input  logic [N_LD-1:0]           ld_is_store,
    input  logic [N_LD-1:0][DW-1:0]   ld_val,
    output logic [N_ADD-1:0]          add_gnt,
    output logic [N_MUL-1:0]          mul_gnt,
    output logic [N_LD-1:0]           ld_gnt,
    output logic                      wb_active,
    output logic                      cdb_valid,
    output logic [TW-1:0]             cdb_tag,
    output logic [DW-1:0]             cdb_value
);
    logic [N_ADD-1:0] add_pick;
    logic [N_MUL-1:0] mul_pick;
    logic [N_LD-1:0]  ld_pick;
    logic [N_LD-1:0]  ld_elig;
    logic             add_any, mul_any, ld_any;
    logic [IDXW-1:0]  add_idx, mul_idx, ld_idx;
    logic [DW-1:0]    add_sel, mul_sel, ld_sel;
    cdb_cls_e         win_cls;
    logic [IDXW-1:0]  win_idx;
    logic [DW-1:0]    win_val;

    // Stores never compete for the bus.
    assign ld_elig = ld_req & ~ld_is_store;

    cdb_prio_pick #(.N(N_ADD), .IW(IDXW), .DW(DW)) i_pick_add (
        .clk(clk), .rst_n(rst_n), .req(add_req), .vals(add_val),
        .gnt(add_pick), .any(add_any), .idx(add_idx), .val(add_sel));

    cdb_prio_pick #(.N(N_MUL), .IW(IDXW), .DW(DW)) i_pick_mul (
        .clk(clk), .rst_n(rst_n), .req(mul_req), .vals(mul_val),
        .gnt(mul_pick), .any(mul_any), .idx(mul_idx), .val(mul_sel));

    cdb_prio_pick #(.N(N_LD), .IW(IDXW), .DW(DW)) i_pick_ld (
        .clk(clk), .rst_n(rst_n), .req(ld_elig), .vals(ld_val),
        .gnt(ld_pick), .any(ld_any), .idx(ld_idx), .val(ld_sel));

    // Gate lower-priority groups behind the higher ones.
    assign add_gnt   = add_pick;
    assign mul_gnt   = add_any ? '0 : mul_pick;
    assign ld_gnt    = (add_any || mul_any) ? '0 : ld_pick;
    assign wb_active = add_any || mul_any || ld_any;

    // Choose the class, index and value of the winning group.
    always_comb begin
        win_cls = CLS_NONE;
        win_idx = '0;
        win_val = '0;
        if (add_any) begin
            win_cls = CLS_ADDSUB;
            win_idx = add_idx;
            win_val = add_sel;
        end else if (mul_any) begin
            win_cls = CLS_MULDIV;
            win_idx = mul_idx;
            win_val = mul_sel;
        end else if (ld_any) begin
            win_cls = CLS_LOAD;
            win_idx = ld_idx;
            win_val = ld_sel;
        end
    end

    cdb_bus_reg #(.TW(TW), .DW(DW)) i_bus (
        .clk(clk), .rst_n(rst_n),
        .nxt_valid(wb_active),
        .nxt_tag({win_cls, win_idx}),
        .nxt_value(win_val),
        .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_value(cdb_value));

    // R1
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({add_gnt, mul_gnt, ld_gnt}));

    // R4
    mul_after_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_gnt != '0) |-> (add_req == '0));

    // R5
    ld_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_gnt != '0) |-> (add_req == '0 && mul_req == '0));

    // R6
    no_store_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_gnt & ld_is_store) == '0);

    // R9
    wb_matches_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_active == ({add_gnt, mul_gnt, ld_gnt} != '0));
endmodule

// File: tb/test_cdb_arbiter.sv
// Self-checking bench: vector table walk, then reset directed tests.
module test_cdb_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N_ADD = 3;
    localparam int N_MUL = 2;
    localparam int N_LD  = 3;
    localparam int DW    = 32;
    localparam int TW    = 4;
    localparam int NV    = 11;

    // {add_req, mul_req, ld_req, ld_store, exp_add_gnt, exp_mul_gnt, exp_ld_gnt, exp_tag}
    localparam logic [22:0] VEC [NV] = '{
        {3'b000, 2'b00, 3'b000, 3'b000, 3'b000, 2'b00, 3'b000, 4'b0000},
        {3'b101, 2'b11, 3'b111, 3'b000, 3'b001, 2'b00, 3'b000, 4'b0100},
        {3'b110, 2'b01, 3'b000, 3'b000, 3'b010, 2'b00, 3'b000, 4'b0101},
        {3'b100, 2'b00, 3'b001, 3'b000, 3'b100, 2'b00, 3'b000, 4'b0110},
        {3'b000, 2'b11, 3'b100, 3'b000, 3'b000, 2'b01, 3'b000, 4'b1000},
        {3'b000, 2'b10, 3'b000, 3'b000, 3'b000, 2'b10, 3'b000, 4'b1001},
        {3'b000, 2'b00, 3'b110, 3'b000, 3'b000, 2'b00, 3'b010, 4'b1101},
        {3'b000, 2'b00, 3'b111, 3'b001, 3'b000, 2'b00, 3'b010, 4'b1101},
        {3'b000, 2'b00, 3'b101, 3'b101, 3'b000, 2'b00, 3'b000, 4'b0000},
        {3'b000, 2'b00, 3'b100, 3'b000, 3'b000, 2'b00, 3'b100, 4'b1110},
        {3'b000, 2'b01, 3'b011, 3'b011, 3'b000, 2'b01, 3'b000, 4'b1000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_ADD-1:0]         add_req = '0;
    logic [N_ADD-1:0][DW-1:0] add_val;
    logic [N_MUL-1:0]         mul_req = '0;
    logic [N_MUL-1:0][DW-1:0] mul_val;
    logic [N_LD-1:0]          ld_req = '0;
    logic [N_LD-1:0]          ld_is_store = '0;
    logic [N_LD-1:0][DW-1:0]  ld_val;
    logic [N_ADD-1:0] add_gnt;
    logic [N_MUL-1:0] mul_gnt;
    logic [N_LD-1:0]  ld_gnt;
    logic             wb_active, cdb_valid;
    logic [TW-1:0]    cdb_tag;
    logic [DW-1:0]    cdb_value;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdb_arbiter i_cdb_arbiter (
        .clk(clk), .rst_n(rst_n),
        .add_req(add_req), .add_val(add_val),
        .mul_req(mul_req), .mul_val(mul_val),
        .ld_req(ld_req), .ld_is_store(ld_is_store), .ld_val(ld_val),
        .add_gnt(add_gnt), .mul_gnt(mul_gnt), .ld_gnt(ld_gnt),
        .wb_active(wb_active), .cdb_valid(cdb_valid),
        .cdb_tag(cdb_tag), .cdb_value(cdb_value));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Value a producer presents, derived from the tag (R7 encoding).
    function automatic logic [DW-1:0] val_of(input logic [TW-1:0] t);
        case (t[3:2])
            2'b01:   return 32'hA000_0000 + 32'(t[1:0]);
            2'b10:   return 32'hB000_0000 + 32'(t[1:0]);
            2'b11:   return 32'hC000_0000 + 32'(t[1:0]);
            default: return '0;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N_ADD; i++) add_val[i] = 32'hA000_0000 + i;
        for (int i = 0; i < N_MUL; i++) mul_val[i] = 32'hB000_0000 + i;
        for (int i = 0; i < N_LD; i++)  ld_val[i]  = 32'hC000_0000 + i;

        // R10: requests held during reset must not reach the bus.
        add_req = 3'b001;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", 64'(cdb_valid), 64'd0);
        chk("R10 reset tag",   64'(cdb_tag),   64'd0);
        chk("R10 reset value", 64'(cdb_value), 64'd0);
        add_req = '0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [22:0] e;
            e = VEC[v];
            add_req     = e[22:20];
            mul_req     = e[19:18];
            ld_req      = e[17:15];
            ld_is_store = e[14:12];
            #1;
            // R2 R3 R4 R5 R6: same-cycle grant
            chk($sformatf("R3 add_gnt v%0d", v), 64'(add_gnt), 64'(e[11:9]));
            chk($sformatf("R4 mul_gnt v%0d", v), 64'(mul_gnt), 64'(e[8:7]));
            chk($sformatf("R5 R6 ld_gnt v%0d", v), 64'(ld_gnt), 64'(e[6:4]));
            chk($sformatf("R1 onehot v%0d", v),
                64'($countones({add_gnt, mul_gnt, ld_gnt})), 64'(e[3:0] != 0));
            chk($sformatf("R9 wb_active v%0d", v), 64'(wb_active), 64'(e[3:0] != 0));
            @(negedge clk);
            // R7 R8: registered broadcast one edge later
            chk($sformatf("R7 R8 valid v%0d", v), 64'(cdb_valid), 64'(e[3:0] != 0));
            chk($sformatf("R7 R8 tag v%0d", v),   64'(cdb_tag),   64'(e[3:0]));
            chk($sformatf("R7 R8 value v%0d", v), 64'(cdb_value), 64'(val_of(e[3:0])));
        end

        // R10: reset mid-run clears a live broadcast.
        add_req = '0; mul_req = 2'b10; ld_req = '0; ld_is_store = '0;
        @(negedge clk);
        chk("R7 pre-reset tag", 64'(cdb_tag), 64'h9);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid reset valid", 64'(cdb_valid), 64'd0);
        chk("R10 mid reset value", 64'(cdb_value), 64'd0);
        rst_n = 1'b1;
        mul_req = '0;
        @(negedge clk);
        chk("R8 idle after reset", 64'(cdb_valid), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule